// File: doc/BRIEF.md
# Bit-Sliced Three-Register ALU Datapath

This block is an N-bit datapath made of N copies of one 1-bit slice. Each slice holds one bit of each of three working registers, a full adder and a small function network.

Two operand buses, A and B, are filled by the registers. Every register has its own enable for each bus, and a bus that no register drives reads as zero. Six one-hot function lines pick what the slice places on the result Z. Z can be written back into any subset of the registers on the next rising clock edge.

Three chains link neighbouring slices: the adder carry, the right-shift path and the left-shift path. Their ends are brought out at the boundary, so wider datapaths can be built by butting blocks together. The same ends also let serial data enter or leave.

Top module: `bitslice_datapath`

## Requirements
- R1: An active-low asynchronous reset clears all three registers to zero.
- R2: Bus A carries the register k whose `a_en[k]` is set and bus B carries the register k whose `b_en[k]` is set. A bus with no enable set reads as all zeros. At most one enable per bus is set at a time.
- R3: With `fn_sel` = 6'b000001, Z is A AND B. With 6'b000010, Z is A OR B. With 6'b000100, Z is A XOR B.
- R4: With `fn_sel` = 6'b001000, Z is the low N bits of A + B + `carry_in`, and `carry_out` is bit N of that sum.
- R5: With `fn_sel` = 6'b010000, Z is A shifted right by one with `shr_in` entering the top bit. `shr_out` always carries bit 0 of bus A.
- R6: With `fn_sel` = 6'b100000, Z is A shifted left by one with `shl_in` entering bit 0. `shl_out` always carries bit N-1 of bus A.
- R7: With no function line set, Z is all zeros whatever the buses carry.
- R8: On a rising clock edge every register k with `ld[k]` set captures Z. Any subset may load together. Registers with `ld[k]` clear keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| fn_sel | input | 6 | One-hot function: bit0 AND, bit1 OR, bit2 XOR, bit3 ADD, bit4 shift right, bit5 shift left |
| ld | input | 3 | Load strobe per register (bit k = register k) |
| a_en | input | 3 | Drive bus A from register k |
| b_en | input | 3 | Drive bus B from register k |
| carry_in | input | 1 | Carry into bit 0 |
| shr_in | input | 1 | Bit entering the top on a right shift |
| shl_in | input | 1 | Bit entering bit 0 on a left shift |
| carry_out | output | 1 | Carry out of the top bit |
| shr_out | output | 1 | Bit 0 of bus A |
| shl_out | output | 1 | Top bit of bus A |
| z | output | N | Combinational ALU result |

## Verification
A wrong register bit shows at the ports only when that register is put on a bus. The bench therefore reads each register back through the OR function, in the cycle after each load. A bad bus enable, function gate or chain link shows on `z` or on the chain outputs in the same cycle its inputs are applied, because the result path has no register. The registers are filled by repeated add-and-double steps. Any carry fault therefore corrupts a loaded value, and this shows up at the next readback.

// File: rtl/bitslice_datapath.sv
module bitslice_datapath #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   fn_sel,
  input  logic [2:0]   ld,
  input  logic [2:0]   a_en,
  input  logic [2:0]   b_en,
  input  logic         carry_in,
  input  logic         shr_in,
  input  logic         shl_in,
  output logic         carry_out,
  output logic         shr_out,
  output logic         shl_out,
  output logic [N-1:0] z
);
  localparam int NREG = 3;

  logic [NREG-1:0][N-1:0] rq;
  logic [N-1:0]           a_bus;
  logic [N-1:0]           b_bus;
  logic [N:0]             cy;

  assign cy[0]     = carry_in;
  assign carry_out = cy[N];
  assign shr_out   = a_bus[0];
  assign shl_out   = a_bus[N-1];

  for (genvar i = 0; i < N; i++) begin : g_slice
    logic [NREG-1:0] q;
    logic            a, b, sr, sl, sum;

    assign a = |(a_en & q);
    assign b = |(b_en & q);
    assign a_bus[i] = a;
    assign b_bus[i] = b;

    if (i == N-1) begin : g_top
      assign sr = shr_in;
    end else begin : g_mid
      assign sr = a_bus[i+1];
    end

    if (i == 0) begin : g_bot
      assign sl = shl_in;
    end else begin : g_up
      assign sl = a_bus[i-1];
    end

    assign sum     = a ^ b ^ cy[i];
    assign cy[i+1] = (a & b) | (cy[i] & (a ^ b));

    assign z[i] = (fn_sel[0] & a & b)
                | (fn_sel[1] & (a | b))
                | (fn_sel[2] & (a ^ b))
                | (fn_sel[3] & sum)
                | (fn_sel[4] & sr)
                | (fn_sel[5] & sl);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= (ld & {NREG{z[i]}}) | (~ld & q);
    end

    for (genvar r = 0; r < NREG; r++) begin : g_tap
      assign rq[r][i] = q[r];
    end
  end
endmodule

module bitslice_datapath_chk #(
  parameter int N = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [5:0]           fn_sel,
  input logic [2:0]           ld,
  input logic [2:0]           a_en,
  input logic [2:0]           b_en,
  input logic                 carry_in,
  input logic                 carry_out,
  input logic                 shr_out,
  input logic                 shl_out,
  input logic [N-1:0]         z,
  input logic [2:0][N-1:0]    rq
);
  AST_A_BUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(a_en)); // R2
  AST_B_BUS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(b_en)); // R2
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (fn_sel == 6'b0) |-> (z == '0)); // R7
  AST_ADD_EMPTY_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (fn_sel == 6'b001000 && a_en == 3'b0 && b_en == 3'b0) |-> (z == N'(carry_in) && !carry_out)); // R4
  AST_SHIFT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (a_en == 3'b001) |-> (shr_out == rq[0][0] && shl_out == rq[0][N-1])); // R5

  for (genvar r = 0; r < 3; r++) begin : g_reg
    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) ld[r] |=> (rq[r] == $past(z))); // R8
    AST_LOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !ld[r] |=> $stable(rq[r])); // R8
  end
endmodule

bind bitslice_datapath bitslice_datapath_chk #(.N(N)) u_chk (.*);

// File: tb/test_bitslice_datapath.sv
module test_bitslice_datapath;
  localparam int N = 8;
  localparam logic [5:0] F_AND = 6'b000001, F_OR = 6'b000010, F_XOR = 6'b000100,
                         F_ADD = 6'b001000, F_SHR = 6'b010000, F_SHL = 6'b100000;

  logic clk = 0, rst_n = 0;
  logic [5:0] fn_sel = '0;
  logic [2:0] ld = '0, a_en = '0, b_en = '0;
  logic carry_in = 0, shr_in = 0, shl_in = 0;
  logic carry_out, shr_out, shl_out;
  logic [N-1:0] z;
  int checks = 0, fails = 0;
  logic [N-1:0] m [3];

  always #5 clk = ~clk;

  bitslice_datapath #(.N(N)) i_bitslice_datapath (
    .clk(clk), .rst_n(rst_n), .fn_sel(fn_sel), .ld(ld), .a_en(a_en), .b_en(b_en),
    .carry_in(carry_in), .shr_in(shr_in), .shl_in(shl_in),
    .carry_out(carry_out), .shr_out(shr_out), .shl_out(shl_out), .z(z));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [5:0] f, input logic [2:0] l, input logic [2:0] a,
                       input logic [2:0] b, input logic ci, input logic sr, input logic sl);
    @(negedge clk);
    fn_sel = f; ld = l; a_en = a; b_en = b; carry_in = ci; shr_in = sr; shl_in = sl;
    #2;
  endtask

  task automatic rd(input int k, output logic [N-1:0] v);
    apply(F_OR, 3'b0, 3'(1 << k), 3'b0, 0, 0, 0);
    v = z;
  endtask

  task automatic load_val(input int k, input logic [N-1:0] v);
    apply(6'b0, 3'(1 << k), 3'b0, 3'b0, 0, 0, 0);
    for (int i = N-1; i >= 0; i--)
      apply(F_ADD, 3'(1 << k), 3'(1 << k), 3'(1 << k), v[i], 0, 0);
    apply(6'b0, 3'b0, 3'b0, 3'b0, 0, 0, 0);
    m[k] = v;
  endtask

  task automatic t_reset;
    logic [N-1:0] v;
    for (int k = 0; k < 3; k++) begin
      rd(k, v);
      chk("R1 reset value", v, 0);
    end
  endtask

  task automatic t_bus;
    load_val(0, 8'hA5); load_val(1, 8'h3C); load_val(2, 8'hF0);
    apply(F_OR, 3'b0, 3'b0, 3'b0, 0, 0, 0);
    chk("R2 empty buses", z, 0);
    apply(F_XOR, 3'b0, 3'b010, 3'b000, 0, 0, 0);
    chk("R2 bus A only", z, m[1]);
    apply(F_OR, 3'b0, 3'b000, 3'b100, 0, 0, 0);
    chk("R2 bus B only", z, m[2]);
  endtask

  task automatic t_logic;
    apply(F_AND, 3'b0, 3'b001, 3'b010, 0, 0, 0); chk("R3 and", z, m[0] & m[1]);
    apply(F_OR,  3'b0, 3'b001, 3'b010, 0, 0, 0); chk("R3 or",  z, m[0] | m[1]);
    apply(F_XOR, 3'b0, 3'b001, 3'b010, 0, 0, 0); chk("R3 xor", z, m[0] ^ m[1]);
  endtask

  task automatic t_add;
    logic [N:0] s;
    for (int ci = 0; ci < 2; ci++) begin
      apply(F_ADD, 3'b0, 3'b001, 3'b100, ci[0], 0, 0);
      s = {1'b0, m[0]} + {1'b0, m[2]} + (N+1)'(ci);
      chk("R4 sum", z, s[N-1:0]);
      chk("R4 carry", carry_out, s[N]);
    end
    apply(F_ADD, 3'b0, 3'b010, 3'b010, 0, 0, 0);
    s = {1'b0, m[1]} + {1'b0, m[1]};
    chk("R4 sum no carry", z, s[N-1:0]);
    chk("R4 carry clear", carry_out, s[N]);
  endtask

  task automatic t_shr;
    apply(F_SHR, 3'b0, 3'b001, 3'b0, 0, 1, 0);
    chk("R5 shift right in1", z, {1'b1, m[0][N-1:1]});
    chk("R5 shr_out", shr_out, m[0][0]);
    apply(F_SHR, 3'b0, 3'b010, 3'b0, 0, 0, 0);
    chk("R5 shift right in0", z, {1'b0, m[1][N-1:1]});
    chk("R5 shr_out low", shr_out, m[1][0]);
  endtask

  task automatic t_shl;
    apply(F_SHL, 3'b0, 3'b100, 3'b0, 0, 0, 1);
    chk("R6 shift left in1", z, {m[2][N-2:0], 1'b1});
    chk("R6 shl_out", shl_out, m[2][N-1]);
    apply(F_SHL, 3'b0, 3'b010, 3'b0, 0, 0, 0);
    chk("R6 shift left in0", z, {m[1][N-2:0], 1'b0});
    chk("R6 shl_out low", shl_out, m[1][N-1]);
  endtask

  task automatic t_idle;
    apply(6'b0, 3'b0, 3'b001, 3'b010, 1, 1, 1);
    chk("R7 idle zero", z, 0);
  endtask

  task automatic t_load;
    logic [N-1:0] v;
    apply(F_AND, 3'b100, 3'b001, 3'b010, 0, 0, 0);
    m[2] = m[0] & m[1];
    rd(0, v); chk("R8 r0 held", v, m[0]);
    rd(1, v); chk("R8 r1 held", v, m[1]);
    rd(2, v); chk("R8 r2 loaded", v, m[2]);
    apply(F_OR, 3'b011, 3'b100, 3'b0, 0, 0, 0);
    m[0] = m[2]; m[1] = m[2];
    rd(0, v); chk("R8 dual load r0", v, m[0]);
    rd(1, v); chk("R8 dual load r1", v, m[1]);
    apply(F_ADD, 3'b0, 3'b001, 3'b001, 1, 0, 0);
    rd(0, v); chk("R8 no strobe", v, m[0]);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset; t_bus; t_logic; t_add; t_shr; t_shl; t_idle; t_load;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule